// File: doc/BRIEF.md
# Byte-Table 16x16 Unsigned Multiplier Sequencer

This block forms the full 32-bit product of two unsigned 16-bit operands while owning only one 8x8 product table. Each operand is split into a high and a low byte, and the table is consulted four times, once for each byte pairing. The table is addressed by the two selected bytes (16 address bits) and is modelled as a combinational lookup.

A fixed seven-step schedule drives the work. Step 1 captures both operands. Step 2 stores the low-by-low product. Step 3 stores the high-by-high product. Step 4 stores the first cross product (X high by Y low). Step 5 loads the accumulator with the high-by-high and low-by-low products placed side by side, with no adder between them, plus the first cross product shifted up one byte. Step 6 stores the second cross product (X low by Y high), and step 7 adds it to the accumulator, shifted up one byte. A one-cycle done pulse then marks the product as valid.

A user raises `start` for one cycle with the operands on `xIn` and `yIn`, then waits for `done`. The product stays on `product` until the next accepted start changes the accumulator.

Top module: `byte_table_mul`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `done` is 0 and `product` is 0.
- R2: When `done` is 1, `product` equals the exact 32-bit unsigned product of the `xIn` and `yIn` values sampled with the accepted `start`.
- R3: A `start` sampled high at a rising edge while the block is idle is accepted, and `done` is 1 in the cycle that follows the seventh rising edge, counting the accepting edge as the first; `done` is 0 in the cycles in between.
- R4: `done` is high for exactly one cycle per accepted start.
- R5: After `done`, `product` keeps its value, for any number of cycles, until a new start is accepted.
- R6: A `start` raised while an operation is in steps 2 to 7 is ignored: the running operation keeps its operands, its result and its `done` timing.
- R7: Only the values of `xIn` and `yIn` at the accepting edge are used; changing them later has no effect on the result.
- R8: Operands with all bits set (0xFFFF times 0xFFFF) give 0xFFFE0001, so that both cross-product additions carry correctly into the top half.
- R9: A `start` sampled high in the cycle where `done` is 1 is accepted; that operation's `done` follows with the same latency as from idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin a multiply |
| xIn | input | 16 | First unsigned operand, sampled on accepted start |
| yIn | input | 16 | Second unsigned operand, sampled on accepted start |
| done | output | 1 | One-cycle pulse: product is valid |
| product | output | 32 | Unsigned product, held until the next accepted start |

## Verification
A wrong byte selection or a misplaced partial product shows up as a wrong `product` in the very cycle `done` rises, so every operation is compared there against a reference product. A sequencer that skips, repeats or stalls a step moves the `done` pulse off the seven-edge mark or widens it, which the bench sees within one operation. An operand register that reloads when it should not is exposed by disturbing `xIn`, `yIn` and `start` mid-operation and checking the result of the original operands.

// File: rtl/bytemul_pkg.sv
package bytemul_pkg;
  // Strobes from the sequencer to the datapath, one set per step.
  typedef struct packed {
    logic ldOps;     // capture both operands
    logic wrP0;      // store low x low product
    logic wrP3;      // store high x high product
    logic wrCross;   // store a cross product (shared register)
    logic wrAcc;     // update the accumulator
    logic selHiX;    // table input from high byte of X
    logic selHiY;    // table input from high byte of Y
    logic accChain;  // 1: add to accumulator, 0: start from placed P3:P0
  } mulStrobe_t;
endpackage

// File: rtl/byte_prod_table.sv
module byte_prod_table #(
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0]   aByte,
  input  logic [BYTE_W-1:0]   bByte,
  output logic [2*BYTE_W-1:0] prodOut
);
  localparam int PP_W = 2 * BYTE_W;

  // Lookup addressed by {aByte, bByte}; contents are the unsigned products.
  always_comb begin
    prodOut = PP_W'(aByte) * PP_W'(bByte);
  end
endmodule

// File: rtl/byte_mul_ctrl.sv
module byte_mul_ctrl
  import bytemul_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  output mulStrobe_t strb,
  output logic       done
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_P0, ST_P3, ST_P1, ST_ACC1, ST_P2, ST_ACC2, ST_DONE
  } seqState_t;

  seqState_t state, stateNext;
  logic accept;

  assign accept = start && (state == ST_IDLE || state == ST_DONE);
  assign done   = (state == ST_DONE);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE, ST_DONE: stateNext = accept ? ST_P0 : ST_IDLE;
      ST_P0:   stateNext = ST_P3;
      ST_P3:   stateNext = ST_P1;
      ST_P1:   stateNext = ST_ACC1;
      ST_ACC1: stateNext = ST_P2;
      ST_P2:   stateNext = ST_ACC2;
      ST_ACC2: stateNext = ST_DONE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  always_comb begin
    strb = '0;
    unique case (state)
      ST_IDLE, ST_DONE: strb.ldOps = accept;
      ST_P0:   strb.wrP0 = 1'b1;
      ST_P3:   begin strb.wrP3 = 1'b1; strb.selHiX = 1'b1; strb.selHiY = 1'b1; end
      ST_P1:   begin strb.wrCross = 1'b1; strb.selHiX = 1'b1; end
      ST_ACC1: strb.wrAcc = 1'b1;
      ST_P2:   begin strb.wrCross = 1'b1; strb.selHiY = 1'b1; end
      ST_ACC2: begin strb.wrAcc = 1'b1; strb.accChain = 1'b1; end
      default: strb = '0;
    endcase
  end

  // R4: the completion pulse never lasts two cycles
  assert_done_single_R4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R3: completion sits exactly seven edges after an accepted start
  assert_done_latency_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(accept, 7));

  // R6: at most one register group is written per step
  assert_one_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.ldOps, strb.wrP0, strb.wrP3, strb.wrCross, strb.wrAcc}));
endmodule

// File: rtl/byte_mul_dpath.sv
module byte_mul_dpath
  import bytemul_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  mulStrobe_t          strb,
  input  logic [2*BYTE_W-1:0] xIn,
  input  logic [2*BYTE_W-1:0] yIn,
  output logic [4*BYTE_W-1:0] product
);
  localparam int OP_W   = 2 * BYTE_W;
  localparam int PP_W   = 2 * BYTE_W;
  localparam int PROD_W = 4 * BYTE_W;

  logic [OP_W-1:0]   opReg [2];
  logic              selHi [2];
  logic [BYTE_W-1:0] opByte [2];
  logic [PP_W-1:0]   tblOut, p0Reg, p3Reg, crossReg;
  logic [PROD_W-1:0] accReg, accBase, crossWide;

  assign selHi[0] = strb.selHiX;
  assign selHi[1] = strb.selHiY;

  always_ff @(posedge clk) begin
    if (rst) begin
      opReg[0] <= '0;
      opReg[1] <= '0;
    end else if (strb.ldOps) begin
      opReg[0] <= xIn;
      opReg[1] <= yIn;
    end
  end

  // Byte selector per operand feeding the shared table.
  for (genvar g = 0; g < 2; g++) begin : gByteSel
    assign opByte[g] = selHi[g] ? opReg[g][OP_W-1:BYTE_W] : opReg[g][BYTE_W-1:0];
  end

  byte_prod_table #(.BYTE_W(BYTE_W)) uTable (
    .aByte  (opByte[0]),
    .bByte  (opByte[1]),
    .prodOut(tblOut)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      p0Reg    <= '0;
      p3Reg    <= '0;
      crossReg <= '0;
    end else begin
      if (strb.wrP0)    p0Reg    <= tblOut;
      if (strb.wrP3)    p3Reg    <= tblOut;
      if (strb.wrCross) crossReg <= tblOut;
    end
  end

  // P3 and P0 are placed side by side; cross products enter one byte up.
  assign accBase   = strb.accChain ? accReg : {p3Reg, p0Reg};
  assign crossWide = {{BYTE_W{1'b0}}, crossReg, {BYTE_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst)              accReg <= '0;
    else if (strb.wrAcc)  accReg <= accBase + crossWide;
  end

  assign product = accReg;

  // R7: captured operands change only on an accepted start
  assert_ops_stable_R7: assert property (@(posedge clk) disable iff (rst)
    !strb.ldOps |=> ($stable(opReg[0]) && $stable(opReg[1])));

  // R5: the result register moves only in the two accumulate steps
  assert_acc_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!strb.wrAcc) |=> $stable(accReg));
endmodule

// File: rtl/byte_table_mul.sv
module byte_table_mul
  import bytemul_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int OP_W   = 2 * BYTE_W,
  localparam int PROD_W = 4 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [OP_W-1:0]   xIn,
  input  logic [OP_W-1:0]   yIn,
  output logic              done,
  output logic [PROD_W-1:0] product
);
  mulStrobe_t strb;

  byte_mul_ctrl uCtrl (
    .clk  (clk),
    .rst  (rst),
    .start(start),
    .strb (strb),
    .done (done)
  );

  byte_mul_dpath #(.BYTE_W(BYTE_W)) uDpath (
    .clk    (clk),
    .rst    (rst),
    .strb   (strb),
    .xIn    (xIn),
    .yIn    (yIn),
    .product(product)
  );

  // R2: the product at completion matches the operands seen seven edges earlier
  assert_product_R2: assert property (@(posedge clk) disable iff (rst)
    done |-> (product == (PROD_W'($past(xIn, 7)) * PROD_W'($past(yIn, 7)))));
endmodule

// File: tb/tb_byte_table_mul.sv
module tb_byte_table_mul;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] xIn = '0;
  logic [15:0] yIn = '0;
  logic        done;
  logic [31:0] product;

  int checkCount = 0;
  int failCount  = 0;
  int cycleCount = 0;

  byte_table_mul dut (
    .clk(clk), .rst(rst), .start(start), .xIn(xIn), .yIn(yIn),
    .done(done), .product(product)
  );

  always #5 clk = ~clk;

  function automatic logic [31:0] refMul(input logic [15:0] a, input logic [15:0] b);
    logic [31:0] acc = '0;
    for (int i = 0; i < 16; i++) if (b[i]) acc = acc + ({16'h0, a} << i);
    return acc;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a negedge: raise start, cross the accepting edge, then scramble inputs (R7).
  task automatic launch(input logic [15:0] a, input logic [15:0] b);
    xIn = a; yIn = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    xIn = 16'($urandom); yIn = 16'($urandom);
  endtask

  // Called one negedge after the accepting edge; ends in the done cycle.
  task automatic finish(input logic [15:0] a, input logic [15:0] b, input bit busyPoke);
    check(done == 1'b0, "R3 done low after accept", {31'h0, done}, 32'h0);
    for (int k = 1; k <= 6; k++) begin
      if (busyPoke && k == 2) begin
        start = 1'b1; xIn = ~a; yIn = b ^ 16'h5a5a;   // R6 ignored start
      end
      @(negedge clk);
      start = 1'b0;
      if (k < 6) check(done == 1'b0, "R3 done early", {31'h0, done}, 32'h0);
      else begin
        check(done == 1'b1, "R3 done at seventh edge", {31'h0, done}, 32'h1);
        check(product == refMul(a, b), busyPoke ? "R6 R2 product" : "R2 product",
              product, refMul(a, b));
      end
    end
  endtask

  task automatic runOp(input logic [15:0] a, input logic [15:0] b, input bit busyPoke);
    logic [31:0] held;
    launch(a, b);
    finish(a, b, busyPoke);
    held = product;
    @(negedge clk);
    check(done == 1'b0, "R4 single done", {31'h0, done}, 32'h0);
    repeat (3) @(negedge clk);
    check(product == held, "R5 product held", product, held);
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cycleCount++;
      if (cycleCount > 100000) begin
        failCount++; checkCount++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] a, b;
    void'($urandom(32'd20240613));
    repeat (3) @(negedge clk);
    check(done == 1'b0 && product == 32'h0, "R1 reset state", product, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check(done == 1'b0 && product == 32'h0, "R1 after reset", product, 32'h0);

    runOp(16'h0000, 16'h1234, 1'b0);
    runOp(16'h0001, 16'hABCD, 1'b0);
    runOp(16'hFFFF, 16'hFFFF, 1'b0);   // R8 full carry case
    check(product == 32'hFFFE0001, "R8 all-ones product", product, 32'hFFFE0001);
    runOp(16'h00FF, 16'hFF00, 1'b0);
    runOp(16'hFF00, 16'h00FF, 1'b0);
    runOp(16'h1234, 16'h5678, 1'b1);   // R6 start during busy

    // R9: back-to-back, new start in the done cycle
    a = 16'hBEEF; b = 16'h0F0F;
    launch(a, b);
    finish(a, b, 1'b0);
    launch(16'hC0DE, 16'h7777);
    check(done == 1'b0, "R9 R4 done dropped after chained start", {31'h0, done}, 32'h0);
    finish(16'hC0DE, 16'h7777, 1'b0);
    @(negedge clk);

    for (int n = 0; n < 40; n++) begin
      a = 16'($urandom); b = 16'($urandom);
      runOp(a, b, (n % 7) == 3);
    end

    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end
endmodule